// File: doc/BRIEF.md
# Processor I/O Port with Decay

This block is an 8-bit bidirectional port that a CPU sees at the two lowest addresses of its memory map. The register at address 0 sets the direction of each pin, where a 1 means the pin is driven. The register at address 1 holds the value that driven pins carry. A read of address 1 returns a value built from three sources: the data register, the direction register and the external pin inputs. Fixed masks shape that value. Bits 0, 1, 2 and 4 read high when they are inputs, and bit 5 reads low when it is an input. The low three bits of the effective output drive a memory-configuration bus that goes to the bank-switching logic.

Bits 6 and 7 have no pin connected. Each one acts like a small capacitor. When the bit is released from output to input, or written while it is an output, its charge holder takes a value and a decay timer starts. A read of address 1 after the deadline has passed returns 0 for that bit, and the read also discharges the holder. A free-running cycle counter supplies the time. The decay period is a parameter so that a test configuration can use a short period.

Top module: `cpu_port_decay`

## Requirements
- R1: After reset the direction register is 0x00 and the data register is 0x3F. Both charge holders read 0, and the configuration output is 3'b111.
- R2: A write with addr=0 loads the direction register and a write with addr=1 loads the data register. With rd_en high, addr=0 returns the direction register in the same cycle. When rd_en is low, rdata is 0x00. pin_out shows the data register and pin_dir shows the direction register.
- R3: Before the bit 5, 6 and 7 rules below are applied, a read of addr=1 returns (data | ~dir) & (pinstate | 0x17), where pinstate = (pin_in & ~dir) | (data & dir).
- R4: cfg_out equals bits 2:0 of (data | ~dir).
- R5: When direction bit 5 is 0, bit 5 of an addr=1 read is 0. Bit 4 is never forced low.
- R6: A direction write that turns bit 6 or bit 7 from output (1) to input (0) loads that bit's charge holder with the current data-register bit. The same write sets the deadline to now plus DECAY_CYCLES.
- R7: A data write while bit 6 or bit 7 is an output loads that bit's charge holder from wdata and re-arms its timer. A data write while the bit is an input leaves the holder unchanged.
- R8: A holder armed at cycle count N keeps its value on reads up to and including count N+DECAY_CYCLES. An addr=1 read at a later count returns 0 for that bit and clears the holder, which then stays 0.
- R9: On an addr=1 read, bit 6 and bit 7 return their holder when their direction bit is 0 and the R3 value when it is 1.
- R10: The cycle counter is 0 in reset and advances by one on every clock.
- R11: Re-arming a holder whose timer is running moves its deadline to the new arm time plus DECAY_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register select: 0 selects direction, 1 selects data |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| rd_en | input | 1 | Read strobe |
| pin_in | input | 8 | External pin levels |
| rdata | output | 8 | Read data, combinational |
| pin_out | output | 8 | Data register, the value driven on output pins |
| pin_dir | output | 8 | Direction register, 1 means output |
| cfg_out | output | 3 | Memory configuration lines |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that the 32-bit cycle counter does not wrap, so every deadline comparison stays monotonic. The stimulus meets both assumptions: each access task drives only one strobe, and the run lasts a few hundred cycles. The bench uses a short decay period. It places reads exactly at the deadline cycle and one cycle after it, counting every access and idle cycle from the arming write.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;

    localparam int PORT_W    = 8;
    localparam int CFG_W     = 3;
    localparam int SENSE_BIT = 5;
    localparam int FLOAT_LO  = 6;
    localparam int N_FLOAT   = PORT_W - FLOAT_LO;

    typedef logic [PORT_W-1:0] port_t;

    localparam port_t PULL_MASK  = 8'h17;
    localparam port_t RESET_DIR  = 8'h00;
    localparam port_t RESET_DATA = 8'h3F;

    typedef enum logic {
        SEL_DIR  = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic dir_we;
        logic data_we;
        logic data_rd;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic wr, input logic rd, input reg_sel_e sel);
        bus_op_t op;
        op.dir_we  = wr && (sel == SEL_DIR);
        op.data_we = wr && (sel == SEL_DATA);
        op.data_rd = rd && !wr && (sel == SEL_DATA);
        return op;
    endfunction

    function automatic port_t base_read(input port_t dat, input port_t dir, input port_t pins_ext);
        port_t pstate;
        port_t v;
        pstate = (pins_ext & ~dir) | (dat & dir);
        v      = (dat | ~dir) & (pstate | PULL_MASK);
        if (!dir[SENSE_BIT]) v[SENSE_BIT] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + TIME_W'(1);
    end

    p_tick_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> now == $past(now) + TIME_W'(1));
endmodule

// File: rtl/port_regs.sv
module port_regs
    import cpu_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    input  port_t   wdata,
    output port_t   dir_q,
    output port_t   data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= RESET_DIR;
            data_q <= RESET_DATA;
        end else begin
            if (op.dir_we)  dir_q  <= wdata;
            if (op.data_we) data_q <= wdata;
        end
    end

    p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
        op.dir_we |=> dir_q == $past(wdata));
    p_data_load_r2: assert property (@(posedge clk) disable iff (rst)
        op.data_we |=> data_q == $past(wdata));
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op.dir_we |=> $stable(dir_q));
endmodule

// File: rtl/decay_cell.sv
module decay_cell #(
    parameter int TIME_W       = 32,
    parameter int DECAY_CYCLES = 350000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  logic              dir_bit,
    input  logic              data_bit,
    input  logic              wdata_bit,
    input  logic              dir_we,
    input  logic              data_we,
    input  logic              data_rd,
    output logic              level
);
    localparam logic [TIME_W-1:0] PERIOD = TIME_W'(DECAY_CYCLES);

    logic              armed;
    logic              charge;
    logic [TIME_W-1:0] deadline;
    logic              arm_release;
    logic              arm_write;
    logic              expired;

    assign arm_release = dir_we && dir_bit && !wdata_bit;
    assign arm_write   = data_we && dir_bit;
    assign expired     = armed && (deadline < now);
    assign level       = expired ? 1'b0 : charge;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            charge   <= 1'b0;
            deadline <= '0;
        end else if (arm_release) begin
            armed    <= 1'b1;
            charge   <= data_bit;
            deadline <= now + PERIOD;
        end else if (arm_write) begin
            armed    <= 1'b1;
            charge   <= wdata_bit;
            deadline <= now + PERIOD;
        end else if (data_rd && expired) begin
            armed  <= 1'b0;
            charge <= 1'b0;
        end
    end

    p_release_arm_r6: assert property (@(posedge clk) disable iff (rst)
        arm_release |=> armed && charge == $past(data_bit));
    p_write_arm_r7: assert property (@(posedge clk) disable iff (rst)
        arm_write |=> armed && charge == $past(wdata_bit));
    p_input_write_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (data_we && !dir_bit) |=> $stable(charge) && $stable(deadline));
    p_discharge_r8: assert property (@(posedge clk) disable iff (rst)
        (data_rd && expired) |=> !armed && !charge);
    p_rearm_deadline_r11: assert property (@(posedge clk) disable iff (rst)
        (arm_release || arm_write) |=> deadline == $past(now) + PERIOD);
endmodule

// File: rtl/cpu_port_decay.sv
module cpu_port_decay
    import cpu_port_pkg::*;
#(
    parameter int DECAY_CYCLES = 350000,
    parameter int TIME_W       = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  pin_in,
    output logic [7:0]  rdata,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_dir,
    output logic [2:0]  cfg_out
);
    bus_op_t            op;
    port_t              dir_q;
    port_t              data_q;
    port_t              rd_val;
    logic [TIME_W-1:0]  now;
    logic [N_FLOAT-1:0] float_lvl;

    assign op = decode_op(wr_en, rd_en, reg_sel_e'(addr));

    tick_counter #(.TIME_W(TIME_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    port_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    for (genvar g = 0; g < N_FLOAT; g++) begin : g_float
        decay_cell #(
            .TIME_W       (TIME_W),
            .DECAY_CYCLES (DECAY_CYCLES)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .now       (now),
            .dir_bit   (dir_q[FLOAT_LO+g]),
            .data_bit  (data_q[FLOAT_LO+g]),
            .wdata_bit (wdata[FLOAT_LO+g]),
            .dir_we    (op.dir_we),
            .data_we   (op.data_we),
            .data_rd   (op.data_rd),
            .level     (float_lvl[g])
        );
    end

    always_comb begin
        rd_val = base_read(data_q, dir_q, pin_in);
        for (int i = 0; i < N_FLOAT; i++) begin
            if (!dir_q[FLOAT_LO+i]) rd_val[FLOAT_LO+i] = float_lvl[i];
        end
    end

    always_comb begin
        if (!rd_en)                             rdata = '0;
        else if (reg_sel_e'(addr) == SEL_DIR)   rdata = dir_q;
        else                                    rdata = rd_val;
    end

    assign pin_out = data_q;
    assign pin_dir = dir_q;
    assign cfg_out = CFG_W'(data_q | ~dir_q);

    p_dir_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr) |-> rdata == pin_dir);
    p_sense_low_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr && !pin_dir[SENSE_BIT]) |-> !rdata[SENSE_BIT]);
    p_cfg_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_out));
    p_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));
endmodule

// File: tb/cpu_port_decay_test.sv
`timescale 1ns/1ps
module cpu_port_decay_test;
    localparam int P = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] rdata;
    logic [7:0] pin_out;
    logic [7:0] pin_dir;
    logic [2:0] cfg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb[$];

    cpu_port_decay #(.DECAY_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .pin_in(pin_in), .rdata(rdata), .pin_out(pin_out),
        .pin_dir(pin_dir), .cfg_out(cfg_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per active read cycle
    always @(negedge clk) begin
        if (rd_en && !done) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: actual 0x%02h expected none", rdata);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                chk(it.tag, rdata, it.exp);
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);

        // reset state
        chk("R1 pin_out", pin_out, 8'h3F);
        chk("R1 pin_dir", pin_dir, 8'h00);
        chk("R1 cfg_out", {5'd0, cfg_out}, 8'h07);
        chk("R2 idle rdata", rdata, 8'h00);
        rd(1'b0, 8'h00, "R1 dir read");
        rd(1'b1, 8'h1F, "R1 R5 data read");

        // data write with bits 6/7 as inputs leaves holders at 0
        wr(1'b1, 8'hFF);
        chk("R2 pin_out", pin_out, 8'hFF);
        rd(1'b1, 8'h1F, "R7 holders untouched");

        // outputs on bits 6/7
        pin_in = 8'h00;
        wr(1'b0, 8'hC0);
        rd(1'b0, 8'hC0, "R2 dir readback");
        rd(1'b1, 8'hD7, "R9 driven bits");
        wr(1'b1, 8'h7F);
        rd(1'b1, 8'h57, "R9 R3 driven data");

        // release to input: holder6=1, holder7=0
        wr(1'b0, 8'h00);
        rd(1'b1, 8'h57, "R6 release charge");
        idle(P - 2);
        rd(1'b1, 8'h57, "R8 R10 at deadline");
        rd(1'b1, 8'h17, "R8 after deadline");
        rd(1'b1, 8'h17, "R8 stays cleared");

        // restart of a running timer
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h00);
        idle(8);
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h00);
        idle(P - 1);
        rd(1'b1, 8'h57, "R11 restarted deadline");
        rd(1'b1, 8'h17, "R11 expires after restart");

        // read formula, pins, configuration
        pin_in = 8'hAA;
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h05);
        chk("R4 cfg", {5'd0, cfg_out}, 8'h05);
        chk("R2 pin_out", pin_out, 8'h05);
        chk("R2 pin_dir", pin_dir, 8'h07);
        rd(1'b1, 8'h1D, "R3 mixed read");
        wr(1'b0, 8'h27);
        wr(1'b1, 8'h25);
        rd(1'b1, 8'h3D, "R5 bit5 driven");
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h02);
        chk("R4 cfg all input", {5'd0, cfg_out}, 8'h07);
        wr(1'b0, 8'h07);
        chk("R4 cfg driven", {5'd0, cfg_out}, 8'h02);

        idle(2);
        if (sb.size() != 0) chk("scoreboard drain", 8'(sb.size()), 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule